// File: doc/BRIEF.md
# Vector Element Fail-First and Predicate-Result Sequencer

This block steps through the elements of one vector operation in order, starting at element 0. For each element an arithmetic or memory pipe hands it the element's 4-bit condition field plus fault and truncation-request flags. The block applies the predicate mask and one single-bit condition test to each element. It then produces three per-element strobes: write the result, write the condition field, and zero the destination. It also decides whether the vector length (VL) is cut short at this element. When the run ends it reports the final VL and a done flag.

There are three operating modes, chosen per run by `cfg_mode`. Predicate-result mode gates result writes on the condition test and may run compare-only. Condition-driven fail-first stops at the first active element whose test fails. Memory fail-first stops at the first active element that faults or asks for an early stop. In memory fail-first, a fault on element 0 is raised as an exception and does not shorten VL. The configuration is latched by a `start` pulse that arrives while the block is idle. Elements then arrive on a valid/ready stream. `in_ready` is high exactly while a run is in progress, and an element transfers on a clock edge where `in_valid` and `in_ready` are both high. The upstream pipe must hold the element's fields stable until that edge. The per-element strobes come out one cycle after acceptance. They have no back-pressure: the register file must take them as they come.

Top module: `vec_ff_seq`

## Requirements
- R1: After reset `done`, `exc`, `el_valid`, every strobe and `new_vl` are 0 and `in_ready` is 0.
- R2: Elements are accepted in order. The k-th accepted element of a run reports `el_idx` = k one cycle after acceptance, with `el_valid` = 1. No index at or beyond the configured VL is ever reported.
- R3: The condition test passes when `in_cond[cfg_bsel]` equals `cfg_pol`, and fails otherwise.
- R4: In predicate-result mode (`cfg_mode` = 0, or 3), an active element writes its condition field when `cfg_rc` or `cfg_rc1` is set. It writes its result only when the test passes.
- R5: When `cfg_rc1` is set, no element's result is ever written in any mode. Only condition fields are written.
- R6: With `cfg_zero` set, a masked-out element is zeroed in every mode. In predicate-result mode, an active element that fails the test is also zeroed. No element is both written and zeroed.
- R7: In condition fail-first mode (`cfg_mode` = 1), the first active element that fails the test writes nothing. The run ends with `new_vl` equal to that element's index, and no later element is accepted. A passing element writes its condition field, and also its result unless `cfg_rc1` is set.
- R8: In condition fail-first mode, a failure on element 0 ends the run with `new_vl` = 0.
- R9: In memory fail-first mode (`cfg_mode` = 2), a fault on active element 0 pulses `exc`, writes nothing, and ends the run with `new_vl` equal to the configured VL.
- R10: In memory fail-first mode, a fault on an active element k > 0 writes nothing and ends the run with `new_vl` = k.
- R11: `in_trunc` on an active element k > 0 ends the run with `new_vl` = k, in memory mode only. It is ignored on element 0 and in the other two modes.
- R12: A masked-out element (`cfg_mask` bit k = 0) is not tested, writes neither result nor condition, and its fault, truncation request and failed test never end the run.
- R13: A run that is not cut short ends after its last element with `new_vl` equal to the configured VL. A run started with VL = 0 ends one cycle after `start` without accepting any element. `done` then stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latches the configuration and begins a run (ignored while busy) |
| cfg_mode | input | 2 | 0 predicate-result, 1 condition fail-first, 2 memory fail-first, 3 as 0 |
| cfg_vl | input | VLW (5) | Vector length of the run, 0 to MAXVL |
| cfg_mask | input | MAXVL (16) | Predicate mask, bit k enables element k |
| cfg_bsel | input | 2 | Index of the tested condition bit |
| cfg_pol | input | 1 | Value the tested bit must have to pass |
| cfg_rc | input | 1 | Record condition fields |
| cfg_rc1 | input | 1 | Compare-only: condition fields written, results never |
| cfg_zero | input | 1 | Zeroing enable |
| in_valid | input | 1 | Element fields are valid |
| in_ready | output | 1 | Block accepts an element this cycle |
| in_cond | input | 4 | Condition field of the element |
| in_fault | input | 1 | Element would fault (memory mode) |
| in_trunc | input | 1 | Request for early stop at this element (memory mode) |
| el_valid | output | 1 | Strobes below refer to element `el_idx` |
| el_idx | output | VLW (5) | Index of the reported element |
| el_res_we | output | 1 | Write the element result |
| el_cond_we | output | 1 | Write the element condition field |
| el_zero_we | output | 1 | Zero the element destination |
| exc | output | 1 | One-cycle pulse: fault on element 0 in memory mode |
| done | output | 1 | Run finished; `new_vl` is valid |
| new_vl | output | VLW (5) | Final vector length of the last run |

## Verification
The bench targets the edges of truncation. It covers a condition failure on element 0, which must yield VL 0; a design that clamps to 1 reports the wrong length. It covers a memory fault on element 0, which must raise `exc` and keep VL; a design that treats it like later faults returns 0. It also sends early-stop requests on element 0 and in the wrong modes, which a sloppy mode decode would honour. Masked elements carry failing condition bits, faults and stop requests, so a design that tests before masking truncates too early. Compare-only runs and zeroing runs confirm that no failing or masked element is written and that passing elements are never zeroed.

// File: rtl/vec_ff_pkg.sv
package vec_ff_pkg;
  typedef enum logic [1:0] {
    MD_PRED  = 2'd0,
    MD_CRFF  = 2'd1,
    MD_MEMFF = 2'd2,
    MD_ALT   = 2'd3
  } ff_mode_e;

  typedef struct packed {
    logic res_we;
    logic cond_we;
    logic zero_we;
    logic stop;
    logic exc;
  } ff_dec_t;
endpackage

// File: rtl/vec_ff_bit_test.sv
module vec_ff_bit_test #(
  parameter int CW = 4
) (
  input  logic [CW-1:0]         cond,
  input  logic [$clog2(CW)-1:0] sel,
  input  logic                  pol,
  output logic                  pass
);
  assign pass = (cond[sel] == pol);
endmodule

// File: rtl/vec_ff_decide.sv
module vec_ff_decide
  import vec_ff_pkg::*;
(
  input  ff_mode_e mode,
  input  logic     active,
  input  logic     pass,
  input  logic     first,
  input  logic     fault,
  input  logic     trunc,
  input  logic     rc,
  input  logic     rc1,
  input  logic     zeroing,
  output ff_dec_t  dec
);
  always_comb begin
    dec = '0;
    if (!active) begin
      dec.zero_we = zeroing;
    end else begin
      unique case (mode)
        MD_CRFF: begin
          if (pass) begin
            dec.res_we  = !rc1;
            dec.cond_we = 1'b1;
          end else begin
            dec.stop = 1'b1;
          end
        end
        MD_MEMFF: begin
          if (fault && first) begin
            dec.exc = 1'b1;
          end else if ((fault || trunc) && !first) begin
            dec.stop = 1'b1;
          end else begin
            dec.res_we  = !rc1;
            dec.cond_we = rc | rc1;
          end
        end
        default: begin
          dec.cond_we = rc | rc1;
          dec.res_we  = pass & !rc1;
          dec.zero_we = zeroing & !pass;
        end
      endcase
    end
  end
endmodule

// File: rtl/vec_ff_seq.sv
module vec_ff_seq
  import vec_ff_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int CW    = 4,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int EW   = $clog2(MAXVL),
  localparam int SW   = $clog2(CW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [VLW-1:0]   cfg_vl,
  input  logic [MAXVL-1:0] cfg_mask,
  input  logic [SW-1:0]    cfg_bsel,
  input  logic             cfg_pol,
  input  logic             cfg_rc,
  input  logic             cfg_rc1,
  input  logic             cfg_zero,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_cond,
  input  logic             in_fault,
  input  logic             in_trunc,
  output logic             el_valid,
  output logic [VLW-1:0]   el_idx,
  output logic             el_res_we,
  output logic             el_cond_we,
  output logic             el_zero_we,
  output logic             exc,
  output logic             done,
  output logic [VLW-1:0]   new_vl
);
  logic             busy;
  logic [VLW-1:0]   idx;
  logic [VLW-1:0]   vl_q;
  logic [MAXVL-1:0] mask_q;
  ff_mode_e         mode_q;
  logic [SW-1:0]    bsel_q;
  logic             pol_q, rc_q, rc1_q, zero_q;

  logic    pass, accept, last, active;
  ff_dec_t dec;

  assign in_ready = busy;
  assign accept   = busy & in_valid;
  assign last     = (idx == vl_q - VLW'(1));
  assign active   = mask_q[idx[EW-1:0]];

  vec_ff_bit_test #(.CW(CW)) u_test (
    .cond (in_cond),
    .sel  (bsel_q),
    .pol  (pol_q),
    .pass (pass)
  );

  vec_ff_decide u_dec (
    .mode    (mode_q),
    .active  (active),
    .pass    (pass),
    .first   (idx == '0),
    .fault   (in_fault),
    .trunc   (in_trunc),
    .rc      (rc_q),
    .rc1     (rc1_q),
    .zeroing (zero_q),
    .dec     (dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      idx        <= '0;
      vl_q       <= '0;
      mask_q     <= '0;
      mode_q     <= MD_PRED;
      bsel_q     <= '0;
      pol_q      <= 1'b0;
      rc_q       <= 1'b0;
      rc1_q      <= 1'b0;
      zero_q     <= 1'b0;
      el_valid   <= 1'b0;
      el_idx     <= '0;
      el_res_we  <= 1'b0;
      el_cond_we <= 1'b0;
      el_zero_we <= 1'b0;
      exc        <= 1'b0;
      done       <= 1'b0;
      new_vl     <= '0;
    end else if (start && !busy) begin
      idx        <= '0;
      vl_q       <= cfg_vl;
      mask_q     <= cfg_mask;
      mode_q     <= ff_mode_e'(cfg_mode);
      bsel_q     <= cfg_bsel;
      pol_q      <= cfg_pol;
      rc_q       <= cfg_rc;
      rc1_q      <= cfg_rc1;
      zero_q     <= cfg_zero;
      el_valid   <= 1'b0;
      el_res_we  <= 1'b0;
      el_cond_we <= 1'b0;
      el_zero_we <= 1'b0;
      exc        <= 1'b0;
      busy       <= (cfg_vl != '0);
      done       <= (cfg_vl == '0);
      new_vl     <= '0;
    end else if (accept) begin
      el_valid   <= 1'b1;
      el_idx     <= idx;
      el_res_we  <= dec.res_we;
      el_cond_we <= dec.cond_we;
      el_zero_we <= dec.zero_we;
      exc        <= dec.exc;
      idx        <= idx + VLW'(1);
      if (dec.stop || dec.exc || last) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        new_vl <= dec.stop ? idx : vl_q;
      end
    end else begin
      el_valid   <= 1'b0;
      el_res_we  <= 1'b0;
      el_cond_we <= 1'b0;
      el_zero_we <= 1'b0;
      exc        <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_ff_seq_chk.sv
module vec_ff_seq_chk #(
  parameter int MAXVL = 16,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int EW   = $clog2(MAXVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             el_valid,
  input logic [VLW-1:0]   el_idx,
  input logic             el_res_we,
  input logic             el_cond_we,
  input logic             el_zero_we,
  input logic             exc,
  input logic             done,
  input logic [VLW-1:0]   new_vl,
  input logic [VLW-1:0]   vl_q,
  input logic [MAXVL-1:0] mask_q,
  input logic [1:0]       mode_q,
  input logic             rc1_q
);
  // R2: reported index stays inside the configured length
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> el_idx < vl_q);

  // R5: compare-only never writes a result
  a_r5_rc1_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && rc1_q |-> !el_res_we);

  // R6: never both written and zeroed
  a_r6_write_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({el_res_we, el_zero_we}));

  // R12: masked elements write nothing
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !mask_q[el_idx[EW-1:0]] |-> !el_res_we && !el_cond_we);

  // R7: a truncated condition run ends on a silent element at the new length
  a_r7_cut_point: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && mode_q == 2'd1 && new_vl < vl_q
      |-> el_valid && !el_res_we && !el_cond_we && el_idx == new_vl);

  // R9: an exception ends the run and keeps the length
  a_r9_exc_keeps_vl: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> done && new_vl == vl_q && !el_res_we);

  // R10: memory mode never ends a nonempty run with length zero
  a_r10_mem_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && mode_q == 2'd2 && vl_q != '0 |-> new_vl != '0);

  // R13: final length never exceeds the configured one
  a_r13_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_vl <= vl_q);
endmodule

bind vec_ff_seq vec_ff_seq_chk #(.MAXVL(MAXVL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .el_valid   (el_valid),
  .el_idx     (el_idx),
  .el_res_we  (el_res_we),
  .el_cond_we (el_cond_we),
  .el_zero_we (el_zero_we),
  .exc        (exc),
  .done       (done),
  .new_vl     (new_vl),
  .vl_q       (vl_q),
  .mask_q     (mask_q),
  .mode_q     (mode_q),
  .rc1_q      (rc1_q)
);

// File: tb/sim_vec_ff_seq.sv
`timescale 1ns/1ps
module sim_vec_ff_seq;
  localparam int MAXVL = 16;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [VLW-1:0] cfg_vl = '0;
  logic [MAXVL-1:0] cfg_mask = '0;
  logic [1:0] cfg_bsel = '0;
  logic cfg_pol = 1'b0, cfg_rc = 1'b0, cfg_rc1 = 1'b0, cfg_zero = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_cond = '0;
  logic in_fault = 1'b0, in_trunc = 1'b0;
  logic el_valid, el_res_we, el_cond_we, el_zero_we, exc, done;
  logic [VLW-1:0] el_idx, new_vl;

  logic [3:0] s_cond [MAXVL];
  logic [MAXVL-1:0] s_fault, s_trunc;
  logic [MAXVL-1:0] g_seen, g_res, g_cond, g_zero;
  logic g_exc;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vec_ff_seq #(.MAXVL(MAXVL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_vl(cfg_vl), .cfg_mask(cfg_mask), .cfg_bsel(cfg_bsel),
    .cfg_pol(cfg_pol), .cfg_rc(cfg_rc), .cfg_rc1(cfg_rc1),
    .cfg_zero(cfg_zero), .in_valid(in_valid), .in_ready(in_ready),
    .in_cond(in_cond), .in_fault(in_fault), .in_trunc(in_trunc),
    .el_valid(el_valid), .el_idx(el_idx), .el_res_we(el_res_we),
    .el_cond_we(el_cond_we), .el_zero_we(el_zero_we), .exc(exc),
    .done(done), .new_vl(new_vl)
  );

  task automatic ck(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < MAXVL; i++) s_cond[i] = 4'h0;
    s_fault = '0;
    s_trunc = '0;
  endtask

  task automatic setup(input logic [1:0] md, input int vl, input logic [MAXVL-1:0] msk,
                       input logic [1:0] bs, input logic pl, input logic rc,
                       input logic rc1, input logic zr);
    cfg_mode = md; cfg_vl = VLW'(vl); cfg_mask = msk; cfg_bsel = bs;
    cfg_pol = pl; cfg_rc = rc; cfg_rc1 = rc1; cfg_zero = zr;
  endtask

  task automatic run();
    int k = 0;
    g_seen = '0; g_res = '0; g_cond = '0; g_zero = '0; g_exc = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int cyc = 0; cyc < int'(cfg_vl) + 4; cyc++) begin
      bit take;
      in_valid = (k < int'(cfg_vl));
      if (k < MAXVL) begin
        in_cond  = s_cond[k];
        in_fault = s_fault[k];
        in_trunc = s_trunc[k];
      end
      take = in_valid && in_ready;
      @(posedge clk);
      if (take) k++;
      @(negedge clk);
      if (el_valid) begin
        g_seen[el_idx[3:0]] = 1'b1;
        g_res[el_idx[3:0]]  = el_res_we;
        g_cond[el_idx[3:0]] = el_cond_we;
        g_zero[el_idx[3:0]] = el_zero_we;
      end
      if (exc) g_exc = 1'b1;
      if (done) break;
    end
    in_valid = 1'b0;
    in_fault = 1'b0;
    in_trunc = 1'b0;
  endtask

  task automatic expect_run(input string tag, input logic [MAXVL-1:0] seen,
                            input logic [MAXVL-1:0] res, input logic [MAXVL-1:0] cnd,
                            input logic [MAXVL-1:0] zer, input int vl, input logic ex);
    ck(done === 1'b1, {tag, " done"}, int'(done), 1);
    ck(in_ready === 1'b0, {tag, " ready low after end"}, int'(in_ready), 0);
    ck(g_seen === seen, {tag, " accepted set"}, int'(g_seen), int'(seen));
    ck(g_res === res, {tag, " result writes"}, int'(g_res), int'(res));
    ck(g_cond === cnd, {tag, " condition writes"}, int'(g_cond), int'(cnd));
    ck(g_zero === zer, {tag, " zero strobes"}, int'(g_zero), int'(zer));
    ck(new_vl === VLW'(vl), {tag, " new VL"}, int'(new_vl), vl);
    ck(g_exc === ex, {tag, " exception"}, int'(g_exc), int'(ex));
  endtask

  task automatic t_reset();
    ck(done === 1'b0 && exc === 1'b0 && el_valid === 1'b0, "R1 control idle",
       int'({done, exc, el_valid}), 0);
    ck({el_res_we, el_cond_we, el_zero_we} === 3'b000, "R1 strobes low",
       int'({el_res_we, el_cond_we, el_zero_we}), 0);
    ck(new_vl === '0 && in_ready === 1'b0, "R1 vl and ready", int'(new_vl), 0);
  endtask

  // R3 R4 R13 R11: bit 1 must be 1; trunc ignored in this mode
  task automatic t_pred_basic();
    clear_stim();
    s_cond[0] = 4'b0010; s_cond[1] = 4'b1101; s_cond[2] = 4'b0110; s_cond[3] = 4'b0000;
    s_trunc[1] = 1'b1;
    setup(2'd0, 4, 16'hFFFF, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    run();
    expect_run("R3 R4 R11 R13 pred", 16'h000F, 16'h0005, 16'h000F, 16'h0000, 4, 1'b0);
  endtask

  // R6 R12: zeroing with a masked element, bit 3 must be 0
  task automatic t_pred_zero();
    clear_stim();
    s_cond[0] = 4'b0111; s_cond[1] = 4'b1000; s_cond[2] = 4'b1000; s_cond[3] = 4'b0001;
    setup(2'd3, 4, 16'b1011, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    run();
    expect_run("R6 R12 pred zero", 16'h000F, 16'b1001, 16'h0000, 16'b0110, 4, 1'b0);
  endtask

  // R5: compare-only with zeroing
  task automatic t_rc1();
    clear_stim();
    s_cond[0] = 4'b0001; s_cond[1] = 4'b0000; s_cond[2] = 4'b0001;
    setup(2'd0, 3, 16'hFFFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    run();
    expect_run("R5 rc1 pred", 16'h0007, 16'h0000, 16'h0007, 16'b010, 3, 1'b0);
  endtask

  // R7 R12: fail on element 2; element 1 masked with a failing bit
  task automatic t_cr_mid();
    clear_stim();
    s_cond[0] = 4'b0100; s_cond[1] = 4'b0000; s_cond[2] = 4'b0000; s_cond[3] = 4'b0100;
    setup(2'd1, 5, 16'b11101, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    run();
    expect_run("R7 R12 cr fail mid", 16'h0007, 16'h0001, 16'h0001, 16'h0000, 2, 1'b0);
  endtask

  // R8: fail on element 0
  task automatic t_cr_zero();
    clear_stim();
    s_cond[0] = 4'b1111;
    setup(2'd1, 6, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    run();
    expect_run("R8 cr fail first", 16'h0001, 16'h0000, 16'h0000, 16'h0000, 0, 1'b0);
  endtask

  // R11 R13: condition mode ignores trunc, all pass
  task automatic t_cr_trunc_ignored();
    clear_stim();
    for (int i = 0; i < 3; i++) s_cond[i] = 4'b1000;
    s_trunc[1] = 1'b1;
    setup(2'd1, 3, 16'hFFFF, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    run();
    expect_run("R11 R5 cr trunc ignored", 16'h0007, 16'h0000, 16'h0007, 16'h0000, 3, 1'b0);
  endtask

  // R9: memory fault on element 0
  task automatic t_mem_first_fault();
    clear_stim();
    s_fault[0] = 1'b1;
    setup(2'd2, 7, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run();
    expect_run("R9 mem fault first", 16'h0001, 16'h0000, 16'h0000, 16'h0000, 7, 1'b1);
  endtask

  // R10: memory fault on element 3
  task automatic t_mem_late_fault();
    clear_stim();
    s_fault[3] = 1'b1;
    setup(2'd2, 8, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run();
    expect_run("R10 mem fault late", 16'h000F, 16'h0007, 16'h0007, 16'h0000, 3, 1'b0);
  endtask

  // R11: trunc on element 0 ignored, honoured on element 2
  task automatic t_mem_trunc();
    clear_stim();
    s_trunc[0] = 1'b1; s_trunc[2] = 1'b1;
    setup(2'd2, 6, 16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run();
    expect_run("R11 mem trunc", 16'h0007, 16'h0003, 16'h0000, 16'h0000, 2, 1'b0);
  endtask

  // R12 R6: masked memory element with fault and trunc, zeroing on
  task automatic t_mem_masked();
    clear_stim();
    s_fault[1] = 1'b1; s_trunc[2] = 1'b1; s_fault[0] = 1'b0;
    setup(2'd2, 4, 16'b1001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    run();
    expect_run("R12 R6 mem masked", 16'h000F, 16'b1001, 16'b1001, 16'b0110, 4, 1'b0);
  endtask

  // R13: empty run
  task automatic t_empty();
    clear_stim();
    setup(2'd1, 0, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run();
    expect_run("R13 empty", 16'h0000, 16'h0000, 16'h0000, 16'h0000, 0, 1'b0);
  endtask

  // R2 R13: full length run, order of indices
  task automatic t_full();
    clear_stim();
    setup(2'd0, MAXVL, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    run();
    expect_run("R2 R13 full length", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, MAXVL, 1'b0);
    repeat (2) @(negedge clk);
    ck(done === 1'b1 && new_vl === VLW'(MAXVL), "R13 done holds", int'(new_vl), MAXVL);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pred_basic();
    t_pred_zero();
    t_rc1();
    t_cr_mid();
    t_cr_zero();
    t_cr_trunc_ignored();
    t_mem_first_fault();
    t_mem_late_fault();
    t_mem_trunc();
    t_mem_masked();
    t_empty();
    t_full();
    finish_run();
  end
endmodule